// File: doc/BRIEF.md
# Shared-Domain Event Counter Bank

This block holds a set of event counters for a subsystem that several cores share, such as a last-level cache, a link layer or a memory controller. Eight general-purpose counters each watch one incoming event stream. Every counter has its own select register that names an event code and a sub-event mask. A free-running fixed counter adds one on every clock. Software reaches all of this through a plain register bus.

Events come in on one strobe per cycle. The strobe carries an event code, a sub-event mask, a transaction address and a command opcode. A counter can also be told to count only events that pass a shared address/opcode match register. One global control word turns each counter on or off. One global status word collects wrap-around flags, and software clears them by writing ones to a separate clear register.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset, the global control, global status, match register, every select register and every counter read as zero.
- R2: The global control word is at address 0x00. Bit n (n = 0 to 7) enables general-purpose counter n and bit 32 enables the fixed counter. All other bits read back as zero.
- R3: While bit 32 of the global control word is set, the fixed counter (address 0x08) rises by one on every clock edge. While that bit is clear, the fixed counter holds its value.
- R4: The select register of counter n is at 0x18+n: code in bits 7:0, sub-event mask in bits 15:8, local enable in bit 22, match-use in bit 23. Counter n (at 0x10+n) rises by one on an edge where the event strobe is high, the event code equals the selected code, the event mask shares at least one set bit with the selected mask, the local enable is set and global control bit n is set.
- R5: A counter does not change on an edge where its global bit or its local enable is clear, where the code differs, or where the masks share no bit.
- R6: The match register is at 0x03: address in bits 15:0, opcode in bits 23:16, address compare enable in bit 62, opcode compare enable in bit 63. A counter whose match-use bit is set counts only events that equal every compare field that is enabled. A counter whose match-use bit is clear ignores the match register.
- R7: When an increment takes a counter from all ones to zero, status bit n (counter n) or status bit 32 (fixed counter) is set in the global status word at 0x01.
- R8: Writing to the overflow clear register at 0x02 clears each status bit whose data bit is one and leaves the other status bits as they were. If a wrap and a clear of the same bit fall on the same edge, the bit ends up set.
- R9: A bus write to a counter address loads the written value. If that counter would also increment on the same edge, the written value is kept and no increment is applied.
- R10: Counters are 48 bits wide. Data bits 63:48 of a counter write are dropped, and those bits always read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for bus_addr (combinational) |
| ev_valid | input | 1 | Event strobe, one event per cycle |
| ev_code | input | 8 | Event code |
| ev_umask | input | 8 | Sub-event mask |
| ev_addr | input | 16 | Transaction address of the event |
| ev_opc | input | 8 | Command opcode of the event |

## Verification
The hardest case to reach from the ports is the wrap-around. A 48-bit counter can never be walked to all ones by events alone. The stimulus first loads the counter one or two steps below all ones through a bus write, then applies events until it wraps, and checks the status bit on the edge that wraps. The clear-versus-wrap collision is harder still. For that case the bench drives an event strobe and an overflow clear write in the same cycle, so that a counter sitting at all ones wraps on the very edge that asks to clear its flag.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam int BUS_AW = 8;
  localparam int BUS_DW = 64;

  localparam logic [BUS_AW-1:0] A_GCTRL    = 8'h00;
  localparam logic [BUS_AW-1:0] A_GSTAT    = 8'h01;
  localparam logic [BUS_AW-1:0] A_OVFCLR   = 8'h02;
  localparam logic [BUS_AW-1:0] A_MATCH    = 8'h03;
  localparam logic [BUS_AW-1:0] A_FIXED    = 8'h08;
  localparam logic [BUS_AW-1:0] A_CNT_BASE = 8'h10;
  localparam logic [BUS_AW-1:0] A_SEL_BASE = 8'h18;

  localparam int FX_BIT        = 32;
  localparam int SEL_EN_BIT    = 22;
  localparam int SEL_QUAL_BIT  = 23;
  localparam int MATCH_ADR_BIT = 62;
  localparam int MATCH_OPC_BIT = 63;

  typedef struct packed {
    logic       qual;
    logic       en;
    logic [7:0] umask;
    logic [7:0] code;
  } sel_t;

  function automatic sel_t sel_unpack(input logic [BUS_DW-1:0] w);
    sel_t s;
    s.code  = w[7:0];
    s.umask = w[15:8];
    s.en    = w[SEL_EN_BIT];
    s.qual  = w[SEL_QUAL_BIT];
    return s;
  endfunction

  function automatic logic [BUS_DW-1:0] sel_pack(input sel_t s);
    logic [BUS_DW-1:0] w;
    w = '0;
    w[7:0]         = s.code;
    w[15:8]        = s.umask;
    w[SEL_EN_BIT]   = s.en;
    w[SEL_QUAL_BIT] = s.qual;
    return w;
  endfunction

  function automatic logic event_selected(input sel_t s, input logic [7:0] code,
                                          input logic [7:0] umask);
    return s.en && (code == s.code) && ((umask & s.umask) != 8'h00);
  endfunction
endpackage

// File: rtl/pcb_event_filter.sv
module pcb_event_filter
  import pcb_pkg::*;
#(
  parameter int ADR_W = 16,
  parameter int OPC_W = 8
) (
  input  sel_t             sel,
  input  logic             ev_valid,
  input  logic [7:0]       ev_code,
  input  logic [7:0]       ev_umask,
  input  logic [ADR_W-1:0] ev_addr,
  input  logic [OPC_W-1:0] ev_opc,
  input  logic [ADR_W-1:0] m_addr,
  input  logic [OPC_W-1:0] m_opc,
  input  logic             m_addr_en,
  input  logic             m_opc_en,
  output logic             hit
);
  logic match_pass;

  always_comb begin
    match_pass = (!m_addr_en || (ev_addr == m_addr)) && (!m_opc_en || (ev_opc == m_opc));
    hit = ev_valid && event_selected(sel, ev_code, ev_umask) && (!sel.qual || match_pass);
  end
endmodule

// File: rtl/pcb_counter.sv
module pcb_counter #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  assign wrap = inc && !load && (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (inc)  cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
  import pcb_pkg::*;
#(
  parameter int NUM_GP = 8,
  parameter int CNT_W  = 48,
  parameter int ADR_W  = 16,
  parameter int OPC_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [7:0]        bus_addr,
  input  logic [63:0]       bus_wdata,
  output logic [63:0]       bus_rdata,
  input  logic              ev_valid,
  input  logic [7:0]        ev_code,
  input  logic [7:0]        ev_umask,
  input  logic [ADR_W-1:0]  ev_addr,
  input  logic [OPC_W-1:0]  ev_opc
);
  localparam int MW = ADR_W + OPC_W;

  logic [NUM_GP-1:0]            gp_en, ovf_gp, gp_hit, gp_inc, gp_load, gp_wrap;
  logic                         fx_en, ovf_fx, fx_load, fx_wrap;
  logic [NUM_GP-1:0][CNT_W-1:0] gp_cnt;
  logic [CNT_W-1:0]             fx_cnt;
  sel_t                         sel_q [NUM_GP];
  logic [MW-1:0]                match_q;
  logic                         m_addr_en, m_opc_en;
  logic                         wr_ctrl, wr_clr, wr_match;

  assign wr_ctrl  = bus_we && (bus_addr == A_GCTRL);
  assign wr_clr   = bus_we && (bus_addr == A_OVFCLR);
  assign wr_match = bus_we && (bus_addr == A_MATCH);
  assign fx_load  = bus_we && (bus_addr == A_FIXED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gp_en     <= '0;
      fx_en     <= 1'b0;
      ovf_gp    <= '0;
      ovf_fx    <= 1'b0;
      match_q   <= '0;
      m_addr_en <= 1'b0;
      m_opc_en  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        gp_en <= bus_wdata[NUM_GP-1:0];
        fx_en <= bus_wdata[FX_BIT];
      end
      if (wr_match) begin
        match_q   <= bus_wdata[MW-1:0];
        m_addr_en <= bus_wdata[MATCH_ADR_BIT];
        m_opc_en  <= bus_wdata[MATCH_OPC_BIT];
      end
      ovf_gp <= (ovf_gp & ~(wr_clr ? bus_wdata[NUM_GP-1:0] : '0)) | gp_wrap;
      ovf_fx <= (ovf_fx && !(wr_clr && bus_wdata[FX_BIT])) || fx_wrap;
    end
  end

  pcb_counter #(.W(CNT_W)) u_fixed (
    .clk(clk), .rst_n(rst_n), .load(fx_load), .load_val(bus_wdata[CNT_W-1:0]),
    .inc(fx_en), .cnt(fx_cnt), .wrap(fx_wrap)
  );

  for (genvar i = 0; i < NUM_GP; i++) begin : g_gp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q[i] <= '0;
      else if (bus_we && (bus_addr == A_SEL_BASE + 8'(i))) sel_q[i] <= sel_unpack(bus_wdata);
    end

    assign gp_load[i] = bus_we && (bus_addr == A_CNT_BASE + 8'(i));
    assign gp_inc[i]  = gp_hit[i] && gp_en[i];

    pcb_event_filter #(.ADR_W(ADR_W), .OPC_W(OPC_W)) u_filt (
      .sel(sel_q[i]), .ev_valid(ev_valid), .ev_code(ev_code), .ev_umask(ev_umask),
      .ev_addr(ev_addr), .ev_opc(ev_opc), .m_addr(match_q[ADR_W-1:0]),
      .m_opc(match_q[MW-1:ADR_W]), .m_addr_en(m_addr_en), .m_opc_en(m_opc_en),
      .hit(gp_hit[i])
    );

    pcb_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(gp_load[i]), .load_val(bus_wdata[CNT_W-1:0]),
      .inc(gp_inc[i]), .cnt(gp_cnt[i]), .wrap(gp_wrap[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_GCTRL) begin
      bus_rdata[NUM_GP-1:0] = gp_en;
      bus_rdata[FX_BIT]     = fx_en;
    end
    if (bus_addr == A_GSTAT) begin
      bus_rdata[NUM_GP-1:0] = ovf_gp;
      bus_rdata[FX_BIT]     = ovf_fx;
    end
    if (bus_addr == A_MATCH) begin
      bus_rdata[MW-1:0]          = match_q;
      bus_rdata[MATCH_ADR_BIT]   = m_addr_en;
      bus_rdata[MATCH_OPC_BIT]   = m_opc_en;
    end
    if (bus_addr == A_FIXED) bus_rdata[CNT_W-1:0] = fx_cnt;
    for (int i = 0; i < NUM_GP; i++) begin
      if (bus_addr == A_CNT_BASE + 8'(i)) bus_rdata[CNT_W-1:0] = gp_cnt[i];
      if (bus_addr == A_SEL_BASE + 8'(i)) bus_rdata = sel_pack(sel_q[i]);
    end
  end
endmodule

// File: rtl/pcb_checker.sv
module pcb_checker #(
  parameter int NUM_GP = 8,
  parameter int CW     = 48
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_GP-1:0]         gp_en,
  input logic [NUM_GP-1:0]         gp_load,
  input logic [NUM_GP-1:0]         gp_wrap,
  input logic [NUM_GP-1:0]         ovf_gp,
  input logic [NUM_GP-1:0][CW-1:0] gp_cnt,
  input logic                      fx_en,
  input logic                      fx_load,
  input logic                      fx_wrap,
  input logic                      ovf_fx,
  input logic [CW-1:0]             fx_cnt,
  input logic [63:0]               wdata
);
  p_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (ovf_gp == '0 && !ovf_fx && fx_cnt == '0));

  p_fixed_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fx_en && !fx_load) |=> fx_cnt == CW'($past(fx_cnt) + 1'b1));

  p_fixed_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fx_en && !fx_load) |=> $stable(fx_cnt));

  p_fx_wrap_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fx_wrap |=> ovf_fx);

  p_gp_wrap_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|gp_wrap) |=> ((ovf_gp & $past(gp_wrap)) == $past(gp_wrap)));

  p_fx_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fx_load |=> fx_cnt == $past(wdata[CW-1:0]));

  for (genvar i = 0; i < NUM_GP; i++) begin : g_chk
    p_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!gp_load[i] && !gp_en[i]) |=> $stable(gp_cnt[i]));

    p_gp_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      gp_load[i] |=> gp_cnt[i] == $past(wdata[CW-1:0]));
  end
endmodule

bind perf_counter_bank pcb_checker #(.NUM_GP(NUM_GP), .CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .gp_en(gp_en), .gp_load(gp_load), .gp_wrap(gp_wrap),
  .ovf_gp(ovf_gp), .gp_cnt(gp_cnt), .fx_en(fx_en), .fx_load(fx_load),
  .fx_wrap(fx_wrap), .ovf_fx(ovf_fx), .fx_cnt(fx_cnt), .wdata(bus_wdata)
);

// File: tb/perf_counter_bank_tb.sv
module perf_counter_bank_tb;
  localparam logic [63:0] MAX48 = 64'h0000_FFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic        ev_valid = 1'b0;
  logic [7:0]  ev_code = 8'h00, ev_umask = 8'h00;
  logic [15:0] ev_addr = 16'h0;
  logic [7:0]  ev_opc = 8'h00;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  perf_counter_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_valid(ev_valid),
    .ev_code(ev_code), .ev_umask(ev_umask), .ev_addr(ev_addr), .ev_opc(ev_opc)
  );

  function automatic logic [63:0] mk_sel(input logic [7:0] code, input logic [7:0] um,
                                         input bit en, input bit qual);
    return {40'h0, qual, en, 6'h0, um, code};
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%016h expected 0x%016h", req, got, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [63:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic bw(input logic [7:0] a, input logic [63:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic set_ev(input logic [7:0] c, input logic [7:0] u,
                        input logic [15:0] a, input logic [7:0] o);
    ev_valid = 1'b1; ev_code = c; ev_umask = u; ev_addr = a; ev_opc = o;
  endtask

  task automatic ev(input logic [7:0] c, input logic [7:0] u,
                    input logic [15:0] a, input logic [7:0] o);
    set_ev(c, u, a, o);
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic t_reset();
    rd_chk("R1 ctrl", 8'h00, 64'h0);
    rd_chk("R1 status", 8'h01, 64'h0);
    rd_chk("R1 match", 8'h03, 64'h0);
    rd_chk("R1 fixed", 8'h08, 64'h0);
    rd_chk("R1 cnt0", 8'h10, 64'h0);
    rd_chk("R1 sel7", 8'h1F, 64'h0);
  endtask

  task automatic t_ctrl();
    bw(8'h00, '1);
    rd_chk("R2 ctrl readback", 8'h00, 64'h0000_0001_0000_00FF);
    bw(8'h00, 64'h0);
    bw(8'h08, 64'h0);
    rd_chk("R2 ctrl off", 8'h00, 64'h0);
  endtask

  task automatic t_fixed();
    bw(8'h00, 64'h1 << 32);
    rd_chk("R3 fixed start", 8'h08, 64'd0);
    repeat (10) @(negedge clk);
    rd_chk("R3 fixed ten", 8'h08, 64'd10);
    bw(8'h00, 64'h0);
    rd_chk("R3 fixed last edge", 8'h08, 64'd11);
    repeat (5) @(negedge clk);
    rd_chk("R3 fixed holds", 8'h08, 64'd11);
  endtask

  task automatic t_select();
    bw(8'h18, mk_sel(8'h2E, 8'h41, 1, 0));
    bw(8'h1B, mk_sel(8'h10, 8'hFF, 1, 0));
    rd_chk("R4 sel readback", 8'h18, 64'h0040_412E);
    bw(8'h00, 64'h09);
    ev(8'h2E, 8'h01, 16'h0, 8'h0);
    ev(8'h2E, 8'h40, 16'h0, 8'h0);
    rd_chk("R4 two hits", 8'h10, 64'd2);
    ev(8'h2E, 8'h02, 16'h0, 8'h0);
    rd_chk("R5 mask no overlap", 8'h10, 64'd2);
    ev(8'h2F, 8'h01, 16'h0, 8'h0);
    rd_chk("R5 code differs", 8'h10, 64'd2);
    ev(8'h10, 8'h80, 16'h0, 8'h0);
    rd_chk("R4 cnt3 own event", 8'h13, 64'd1);
    rd_chk("R5 cnt0 other event", 8'h10, 64'd2);
    bw(8'h18, mk_sel(8'h2E, 8'h41, 0, 0));
    ev(8'h2E, 8'h01, 16'h0, 8'h0);
    rd_chk("R5 local enable clear", 8'h10, 64'd2);
    bw(8'h18, mk_sel(8'h2E, 8'h41, 1, 0));
    bw(8'h00, 64'h08);
    ev(8'h2E, 8'h01, 16'h0, 8'h0);
    rd_chk("R5 global bit clear", 8'h10, 64'd2);
  endtask

  task automatic t_match();
    bw(8'h11, 64'h0);
    bw(8'h19, mk_sel(8'h05, 8'h01, 1, 1));
    bw(8'h1A, mk_sel(8'h05, 8'h01, 1, 0));
    bw(8'h00, 64'h06);
    bw(8'h12, 64'h0);
    bw(8'h03, (64'h1 << 62) | 64'h0007_1234);
    ev(8'h05, 8'h01, 16'h1234, 8'h00);
    rd_chk("R6 address equal", 8'h11, 64'd1);
    ev(8'h05, 8'h01, 16'h1235, 8'h07);
    rd_chk("R6 address differs", 8'h11, 64'd1);
    rd_chk("R6 unqualified ignores match", 8'h12, 64'd2);
    bw(8'h03, (64'h1 << 63) | 64'h0007_1234);
    ev(8'h05, 8'h01, 16'hBEEF, 8'h07);
    rd_chk("R6 opcode equal", 8'h11, 64'd2);
    ev(8'h05, 8'h01, 16'h1234, 8'h06);
    rd_chk("R6 opcode differs", 8'h11, 64'd2);
    bw(8'h03, (64'h3 << 62) | 64'h0007_1234);
    ev(8'h05, 8'h01, 16'h1234, 8'h06);
    ev(8'h05, 8'h01, 16'h1234, 8'h07);
    rd_chk("R6 both fields", 8'h11, 64'd3);
  endtask

  task automatic t_wrap();
    bw(8'h00, 64'h0);
    bw(8'h1A, mk_sel(8'h33, 8'h01, 1, 0));
    bw(8'h12, MAX48 - 1);
    bw(8'h08, MAX48 - 1);
    bw(8'h00, (64'h1 << 32) | 64'h04);
    ev(8'h33, 8'h01, 16'h0, 8'h0);
    rd_chk("R7 cnt2 at max", 8'h12, MAX48);
    rd_chk("R7 no flag yet", 8'h01, 64'h0);
    ev(8'h33, 8'h01, 16'h0, 8'h0);
    rd_chk("R7 cnt2 wrapped", 8'h12, 64'h0);
    rd_chk("R7 status bits 2 and 32", 8'h01, (64'h1 << 32) | 64'h04);
    bw(8'h00, 64'h04);
  endtask

  task automatic t_clear();
    bw(8'h02, 64'h04);
    rd_chk("R8 clear only bit2", 8'h01, 64'h1 << 32);
    bw(8'h12, MAX48);
    set_ev(8'h33, 8'h01, 16'h0, 8'h0);
    bw(8'h02, 64'h04);
    ev_valid = 1'b0;
    rd_chk("R8 wrap beats clear", 8'h01, (64'h1 << 32) | 64'h04);
    bw(8'h02, '1);
    rd_chk("R8 clear all", 8'h01, 64'h0);
  endtask

  task automatic t_load();
    bw(8'h00, 64'h01);
    set_ev(8'h2E, 8'h01, 16'h0, 8'h0);
    bw(8'h10, 64'h100);
    ev_valid = 1'b0;
    rd_chk("R9 write beats increment", 8'h10, 64'h100);
    ev(8'h2E, 8'h01, 16'h0, 8'h0);
    rd_chk("R9 counts after load", 8'h10, 64'h101);
    bw(8'h10, 64'hFFFF_0000_0000_0005);
    rd_chk("R10 upper bits dropped", 8'h10, 64'h5);
    bw(8'h08, '1);
    rd_chk("R10 fixed width", 8'h08, MAX48);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_fixed();
    t_select();
    t_match();
    t_wrap();
    t_clear();
    t_load();
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end
endmodule